// File: doc/BRIEF.md
# Cascaded Serial DAC Frame Loader

This block sits on the host side of a chain of 16-bit serial-input converters that share one serial clock, one select line for their input shift registers and one or more update lines. The data output of each converter feeds the data input of the next, so the whole chain behaves as one long shift register. The block takes one word per device over a valid/ready stream and buffers the full frame. It then generates the serial clock from the system clock by a fixed divider and shifts the frame out. Finally it pulses the update line or lines so that the converter outputs take the new words.

Words are numbered by position in the chain. Word 0 is for the device wired directly to the block, and word NDEV-1 is for the device at the far end. The stream delivers the words in that order, word 0 first. The shifter sends the far-end word first, each word most significant bit first, so that after `WORD_W*NDEV` serial clocks every device holds its own word.

A parameter selects the update topology. In one topology a single shared update line loads every device at once. In the other, each device has its own update line, and a device mask taken with the last word of the frame chooses which devices load.

Top module: `dchain_loader`

## Requirements
- R1: After reset `s_ready` is 1, `dac_clk` is 0, `dac_sdi` is 0, `dac_a0_n` is 1 and every bit of `dac_a1_n` is 1.
- R2: `s_ready` stays high while a frame is being collected, including idle gaps between beats. It drops in the cycle after the NDEV-th accepted word and stays low until the update pulse has ended. `s_valid` asserted while `s_ready` is low has no effect.
- R3: While `dac_a0_n` is low (active-low shift select), `dac_clk` makes exactly `WORD_W*NDEV` rising edges. The frame contains exactly one further rising edge, and it falls inside the update window.
- R4: The bits are sent in this order: the word for device NDEV-1 first, down to the word for device 0, each word MSB first. After the update, each updated device's output register holds the word sent for its position.
- R5: `dac_sdi` changes only while `dac_clk` is low. It is stable for the whole high phase.
- R6: Inside a shift or update window, every low phase and every high phase of `dac_clk` lasts exactly `HALF_CYC` system cycles.
- R7: `dac_a0_n` and `dac_a1_n` change only while `dac_clk` is low. No update line is low while `dac_a0_n` is low.
- R8: With `PER_DEV_UPD=0`, the single line `dac_a1_n[0]` goes low for one serial clock period, so that one rising edge loads every device. `s_mask` is ignored.
- R9: With `PER_DEV_UPD=1`, line `dac_a1_n[k]` goes low during the update window only when bit k of the `s_mask` value presented with the last word is 1. Devices whose bit is 0 keep their previous output word. `s_mask` values on earlier beats are ignored.
- R10: After the update, a new frame is accepted and processed on its own. Its result does not depend on the earlier frame, except that devices left unselected keep their old words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Word valid |
| s_ready | output | 1 | Ready to accept a word |
| s_data | input | WORD_W | Word for the device at the current position |
| s_mask | input | NDEV | Update select per device, taken on the last beat |
| dac_clk | output | 1 | Serial clock to the chain |
| dac_sdi | output | 1 | Serial data to the first device |
| dac_a0_n | output | 1 | Active-low shift-register select, common to the chain |
| dac_a1_n | output | PER_DEV_UPD ? NDEV : 1 | Active-low update line(s) |

## Verification
The hardest case to reach from the ports is a selective update. Only some devices load, and the others must be shown to keep words from an earlier frame. The stimulus therefore runs several back-to-back frames with different masks and distinct words. On the non-final beats it presents the inverted mask, so a mask taken from the wrong beat shows up as a wrong output word. A scoreboard tracks the expected register of every modelled converter across frames. A second instance with a shared update line runs the same traffic, including an all-zero mask that it must ignore. Phase widths, bit counts and control-edge placement are measured at the serial pins on every frame.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_SHIFT   = 2'd1,
      ST_STROBE  = 2'd2
   } dcl_state_t;
endpackage

// File: rtl/dcl_halftick.sv
module dcl_halftick #(
   parameter int HALF_CYC = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   logic [CW-1:0] cnt_q;

   generate
      if (HALF_CYC < 1) begin : g_bad
         $error("dcl_halftick: HALF_CYC must be at least 1");
      end
   endgenerate

   assign tick = run && (cnt_q == CW'(HALF_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R6: the count never passes the half period limit
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(HALF_CYC - 1));
endmodule

// File: rtl/dcl_frame_buf.sv
module dcl_frame_buf #(
   parameter int NDEV   = 3,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [((NDEV > 1) ? $clog2(NDEV) : 1)-1:0] wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              shift,
   output logic              head_bit
);
   localparam int TOT = NDEV * WORD_W;

   logic [TOT-1:0] frame_q;

   generate
      if (NDEV < 1) begin : g_bad_n
         $error("dcl_frame_buf: NDEV must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_w
         $error("dcl_frame_buf: WORD_W must be at least 2");
      end
   endgenerate

   // Slice k holds the word for chain position k; the top slice leaves first.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       frame_q <= '0;
      else if (wr)      frame_q[int'(wr_idx)*WORD_W +: WORD_W] <= wr_data;
      else if (shift)   frame_q <= {frame_q[TOT-2:0], 1'b0};
   end

   assign head_bit = frame_q[TOT-1];

   // R4: loading and shifting never overlap
   a_r4_no_wr_shift: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && shift));
endmodule

// File: rtl/dcl_strobe_sel.sv
module dcl_strobe_sel #(
   parameter int NDEV        = 3,
   parameter bit PER_DEV_UPD = 1'b1,
   localparam int A1W        = PER_DEV_UPD ? NDEV : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap,
   input  logic [NDEV-1:0] mask_in,
   input  logic            active,
   output logic [A1W-1:0]  upd_n
);
   generate
      if (PER_DEV_UPD) begin : g_per_dev
         logic [NDEV-1:0] mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mask_q <= '0;
            else if (cap) mask_q <= mask_in;
         end
         assign upd_n = ~(mask_q & {NDEV{active}});

         // R9: the selection cannot move during an update window
         a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            active |-> !cap);
      end else begin : g_shared
         assign upd_n = ~active;
      end
   endgenerate
endmodule

// File: rtl/dchain_loader.sv
module dchain_loader
   import dcl_pkg::*;
#(
   parameter int NDEV        = 3,
   parameter int WORD_W      = 16,
   parameter int HALF_CYC    = 13,
   parameter bit PER_DEV_UPD = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                s_valid,
   output logic                                s_ready,
   input  logic [WORD_W-1:0]                   s_data,
   input  logic [NDEV-1:0]                     s_mask,
   output logic                                dac_clk,
   output logic                                dac_sdi,
   output logic                                dac_a0_n,
   output logic [(PER_DEV_UPD ? NDEV : 1)-1:0] dac_a1_n
);
   localparam int TOT = NDEV * WORD_W;
   localparam int IW  = (NDEV > 1) ? $clog2(NDEV) : 1;
   localparam int BW  = $clog2(TOT);
   localparam int RW  = $clog2(TOT + 1);
   localparam int A1W = PER_DEV_UPD ? NDEV : 1;

   generate
      if (NDEV < 1) begin : g_bad_n
         $error("dchain_loader: NDEV must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_w
         $error("dchain_loader: WORD_W must be at least 2");
      end
   endgenerate

   dcl_state_t    st_q;
   logic          ph_q;
   logic [IW-1:0] wcnt_q;
   logic [BW-1:0] bcnt_q;
   logic          tick;
   logic          accept;
   logic          last_beat;
   logic          fall_now;
   logic          head_bit;

   assign accept    = s_valid && s_ready;
   assign last_beat = (wcnt_q == IW'(NDEV - 1));
   assign fall_now  = tick && ph_q;

   dcl_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st_q != ST_COLLECT),
      .tick (tick)
   );

   dcl_frame_buf #(.NDEV(NDEV), .WORD_W(WORD_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (accept),
      .wr_idx  (wcnt_q),
      .wr_data (s_data),
      .shift   ((st_q == ST_SHIFT) && fall_now),
      .head_bit(head_bit)
   );

   dcl_strobe_sel #(.NDEV(NDEV), .PER_DEV_UPD(PER_DEV_UPD)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (accept && last_beat),
      .mask_in(s_mask),
      .active (st_q == ST_STROBE),
      .upd_n  (dac_a1_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_COLLECT;
         ph_q   <= 1'b0;
         wcnt_q <= '0;
         bcnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_COLLECT: begin
               if (accept) begin
                  if (last_beat) begin
                     wcnt_q <= '0;
                     bcnt_q <= '0;
                     ph_q   <= 1'b0;
                     st_q   <= ST_SHIFT;
                  end else begin
                     wcnt_q <= wcnt_q + 1'b1;
                  end
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  ph_q <= ~ph_q;
                  if (ph_q) begin
                     if (bcnt_q == BW'(TOT - 1)) st_q <= ST_STROBE;
                     else                        bcnt_q <= bcnt_q + 1'b1;
                  end
               end
            end
            ST_STROBE: begin
               if (tick) begin
                  ph_q <= ~ph_q;
                  if (ph_q) st_q <= ST_COLLECT;
               end
            end
            default: st_q <= ST_COLLECT;
         endcase
      end
   end

   assign s_ready  = (st_q == ST_COLLECT);
   assign dac_clk  = ph_q;
   assign dac_sdi  = (st_q == ST_SHIFT) ? head_bit : 1'b0;
   assign dac_a0_n = (st_q != ST_SHIFT);

   // Edge counter watched by the assertions below
   logic          clk_d_q;
   logic [RW-1:0] rise_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d_q <= 1'b0;
         rise_q  <= '0;
      end else begin
         clk_d_q <= dac_clk;
         if (dac_a0_n)                 rise_q <= '0;
         else if (dac_clk && !clk_d_q) rise_q <= rise_q + 1'b1;
      end
   end

   // R2: nothing is accepted while shifting
   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_a0_n |-> !s_ready);
   // R3: one shift window holds exactly one frame of rising edges
   a_r3_frame_edges: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_a0_n) |-> (rise_q == RW'(TOT)));
   // R5: data is held through every high phase
   a_r5_sdi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dac_clk |-> $stable(dac_sdi));
   // R7: control lines move only with the serial clock low
   a_r7_a0_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_a0_n) |-> !dac_clk);
   a_r7_a1_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_a1_n) |-> !dac_clk);
   // R7: shift select and update are never active together
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_a0_n |-> (dac_a1_n == {A1W{1'b1}}));
endmodule

// File: tb/sim_dchain_loader.sv
module cv_model (
   input  logic        sclk,
   input  logic        sdi,
   input  logic        a0_n,
   input  logic        a1_n,
   output logic        sdo,
   output logic [15:0] out_q
);
   logic [15:0] sr = '0;
   initial out_q = '0;
   always @(posedge sclk) begin
      if (!a0_n) sr <= {sr[14:0], sdi};
      if (!a1_n) out_q <= sr;
   end
   assign sdo = sr[15];
endmodule

module sim_dchain_loader;
   localparam int ND = 3;
   localparam int W  = 16;
   localparam int HC = 13;
   localparam int FW = ND * W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_valid = 1'b0;
   logic [W-1:0] s_data = '0;
   logic [ND-1:0] s_mask = '0;
   always #2 clk = ~clk;

   logic r0, r1, c0, c1, d0, d1, a00, a01;
   logic [ND-1:0] a10;
   logic [0:0]    a11;

   dchain_loader #(.NDEV(ND), .WORD_W(W), .HALF_CYC(HC), .PER_DEV_UPD(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(r0), .s_data(s_data),
      .s_mask(s_mask), .dac_clk(c0), .dac_sdi(d0), .dac_a0_n(a00), .dac_a1_n(a10));
   dchain_loader #(.NDEV(ND), .WORD_W(W), .HALF_CYC(HC), .PER_DEV_UPD(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(r1), .s_data(s_data),
      .s_mask(s_mask), .dac_clk(c1), .dac_sdi(d1), .dac_a0_n(a01), .dac_a1_n(a11));

   logic [ND:0] ch0, ch1;
   logic [FW-1:0] out0, out1;
   assign ch0[0] = d0;
   assign ch1[0] = d1;
   for (genvar k = 0; k < ND; k++) begin : g_dev
      cv_model m0 (.sclk(c0), .sdi(ch0[k]), .a0_n(a00), .a1_n(a10[k]),
                   .sdo(ch0[k+1]), .out_q(out0[k*W +: W]));
      cv_model m1 (.sclk(c1), .sdi(ch1[k]), .a0_n(a01), .a1_n(a11[0]),
                   .sdo(ch1[k+1]), .out_q(out1[k*W +: W]));
   end

   int nchk = 0, nerr = 0;
   bit done = 1'b0;
   logic [FW-1:0] q0[$], q1[$];
   logic [FW-1:0] sh0 = '0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: presents one frame and pushes the expected device words
   task automatic send_frame(input logic [FW-1:0] fw, input logic [ND-1:0] m, input int gap, input int junk);
      logic [FW-1:0] e0;
      while (!r0) @(negedge clk);
      for (int k = 0; k < ND; k++) begin
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = fw[k*W +: W];
         s_mask  = (k == ND - 1) ? m : ~m;   // R9: earlier beats carry a decoy mask
         @(posedge clk);
         if (k != ND - 1) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               s_valid = 1'b0;
               chk(r0 == 1'b1, "R2 ready during gap", r0, 1);
            end
         end
      end
      @(negedge clk);
      chk(r0 == 1'b0, "R2 ready after last word", r0, 0);
      chk(a00 == 1'b0, "R3 shift select active", a00, 0);
      s_valid = (junk > 0);
      s_data  = 16'hDEAD;
      for (int j = 0; j < junk; j++) @(negedge clk);   // R2: ignored while busy
      s_valid = 1'b0;
      e0 = sh0;
      for (int k = 0; k < ND; k++) if (m[k]) e0[k*W +: W] = fw[k*W +: W];
      sh0 = e0;
      q0.push_back(e0);
      q1.push_back(fw);
   endtask

   // Monitor: pin timing plus scoreboard compare at frame end
   logic pc = 1'b0, pd = 1'b0, pa0 = 1'b1, pr = 1'b1;
   logic [ND-1:0] pa1 = '1;
   logic [0:0] pa1s = 1'b1;
   int run = 0, rise_sh = 0, rise_up = 0, rise_up1 = 0;
   bit v5 = 1'b0, v6 = 1'b0, v7 = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (c0 !== pc) begin
            if (pc || !pa0 || (pa1 != '1)) if (run != HC) v6 = 1'b1;
            run = 1;
            if (c0) begin
               if (!a00) rise_sh++;
               if (a10 != '1 || (pa1 != '1)) rise_up++;
            end
         end else if (a00 !== pa0 || a10 !== pa1) begin
            run = 1;
         end else begin
            run++;
         end
         if (c1 && !pc && !a11[0]) rise_up1++;
         if (d0 !== pd && c0) v5 = 1'b1;
         if ((a00 !== pa0 || a10 !== pa1 || a11 !== pa1s) && c0) v7 = 1'b1;
         if (!a00 && a10 != '1) v7 = 1'b1;
         if (r0 && !pr) begin
            logic [FW-1:0] e0, e1;
            e0 = q0.pop_front();
            e1 = q1.pop_front();
            chk(out0 == e0, "R4 R9 per-device outputs", out0, e0);
            chk(out1 == e1, "R4 R8 shared outputs", out1, e1);
            chk(rise_sh == FW, "R3 edges in shift window", rise_sh, FW);
            chk(rise_up1 == 1, "R8 one update edge", rise_up1, 1);
            chk(!v5, "R5 sdi stable in high phase", v5, 0);
            chk(!v6, "R6 phase width", v6, 0);
            chk(!v7, "R7 control edge placement", v7, 0);
            chk(r1 == 1'b1, "R10 both ready again", r1, 1);
            rise_sh = 0; rise_up = 0; rise_up1 = 0;
            v5 = 1'b0; v6 = 1'b0; v7 = 1'b0;
         end
         pc = c0; pd = d0; pa0 = a00; pa1 = a10; pa1s = a11; pr = r0;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(r0 == 1 && r1 == 1, "R1 ready", {r0, r1}, 2'b11);
      chk(c0 == 0 && d0 == 0, "R1 clk/sdi", {c0, d0}, 0);
      chk(a00 == 1 && a10 == '1 && a11 == 1'b1, "R1 select lines", {a00, a10, a11}, '1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      send_frame({16'h7FFF, 16'hBEEF, 16'h1234}, 3'b111, 0, 0);
      send_frame({16'h8000, 16'h0F0F, 16'hA5A5}, 3'b010, 2, 0);
      send_frame({16'h3333, 16'h2222, 16'h1111}, 3'b000, 0, 10);   // R8: mask ignored when shared
      send_frame({16'h8001, 16'h0000, 16'hFFFF}, 3'b101, 5, 0);
      send_frame({16'h5A5A, 16'hC3C3, 16'h0001}, 3'b100, 1, 3);    // R10: back-to-back frame
      while (q0.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(out0[W +: W] == 16'h0F0F, "R9 unselected device kept word", out0[W +: W], 16'h0F0F);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule